// File: doc/BRIEF.md
# Iterative Integer Divider with Zero-Divisor Trap

This block divides a 32-bit dividend by a 32-bit divisor, either as two's-complement values or as plain unsigned numbers. An operation is accepted over a valid/ready input handshake. A nonzero divisor runs a one-bit-per-cycle restoring loop on the operand magnitudes, and the sign is applied to the quotient when the result is presented. The quotient comes out over a valid/ready output handshake. Only one operation is in flight at a time. The input side is ready only when the block is empty. A presented result stays valid and unchanged until the consumer takes it.

A zero divisor skips the loop and returns a zero quotient on the next cycle. It also sets a sticky divide-by-zero status bit. When the machine's exception-enable bit is set and the suppression configuration bit is clear at acceptance, the result also carries an exception request with the divide-by-zero cause code. Any accepted operation with a nonzero divisor clears the status bit.

Top module: `idiv_unit`

## Requirements
- R1: After reset `in_ready` is 1, and `out_valid`, `dz_status`, `exc_req` and `exc_cause` are 0.
- R2: With `in_signed` = 0 the quotient is the unsigned floor of dividend / divisor.
- R3: With `in_signed` = 1 the operands are two's-complement, and the quotient is truncated toward zero (for example -7 / 2 = -3).
- R4: For a nonzero divisor, `out_valid` first rises after the 32nd rising edge that follows the accepting edge. `out_quotient` reads 0 whenever `out_valid` is 0.
- R5: For a zero divisor, `out_valid` rises right after the accepting edge with quotient 0. From that edge on, `dz_status` reads 1.
- R6: Accepting an operation with a nonzero divisor clears `dz_status` from the accepting edge on.
- R7: `exc_req` is high only while a zero-divisor result is valid, and only if `exc_enable` = 1 and `zexc_suppress` = 0 at acceptance. `exc_cause` reads 5 (5-bit) while `exc_req` is high and 0 otherwise.
- R8: Signed 0x80000000 / 0xFFFFFFFF gives 0x80000000, raises no exception, and clears `dz_status`.
- R9: A valid result holds `out_valid` and `out_quotient` steady until a cycle with `out_ready` = 1. `in_ready` is 1 only with nothing in flight or pending, and `in_valid` is ignored otherwise.
- R10: Changes to `exc_enable` or `zexc_suppress` after acceptance do not affect that operation's `exc_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Block empty, operation accepted when valid |
| in_dividend | input | 32 | Dividend |
| in_divisor | input | 32 | Divisor |
| in_signed | input | 1 | 1 = two's-complement division |
| exc_enable | input | 1 | Machine exception-enable bit |
| zexc_suppress | input | 1 | Configuration bit masking the zero-divide exception |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_quotient | output | 32 | Quotient, 0 when no result is present |
| dz_status | output | 1 | Sticky divide-by-zero status bit |
| exc_req | output | 1 | Exception request, qualified by out_valid |
| exc_cause | output | 5 | Exception cause code, 5 = divide by zero |

## Verification
The bench builds the block with its default 32-bit width. At that width the most-negative-by-minus-one case and the full 32-iteration latency are both exercised exactly as the core would see them. A behavioural model predicts every output on every cycle from the inputs alone. This covers long back-pressure holds, zero divisors under each combination of enable and suppression, stray offers while busy, and control bits that change after acceptance.

// File: rtl/idiv_pkg.sv
package idiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } idiv_state_e;

  localparam int          CAUSE_W       = 5;
  localparam logic [4:0]  CAUSE_DIVZERO = 5'd5;
endpackage

// File: rtl/idiv_prep.sv
module idiv_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  input  logic         is_signed,
  output logic [W-1:0] dvd_mag,
  output logic [W-1:0] dvs_mag,
  output logic         neg_q,
  output logic         dvs_zero
);
  logic neg_a, neg_b;

  always_comb begin
    neg_a    = is_signed & dividend[W-1];
    neg_b    = is_signed & divisor[W-1];
    dvd_mag  = neg_a ? (~dividend + 1'b1) : dividend;
    dvs_mag  = neg_b ? (~divisor + 1'b1) : divisor;
    neg_q    = neg_a ^ neg_b;
    dvs_zero = (divisor == '0);
  end
endmodule

// File: rtl/idiv_core.sv
module idiv_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] dvd_mag,
  input  logic [W-1:0] dvs_mag,
  output logic [W-1:0] quo_mag,
  output logic         last
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] ITER = CW'(W);

  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    shifted, diff;
  logic          fits;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    diff    = shifted - {1'b0, dvs_q};
    fits    = ~diff[W];
    last    = (cnt_q == CW'(1));
    quo_mag = quo_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      rem_q <= '0;
      quo_q <= dvd_mag;
      dvs_q <= dvs_mag;
      cnt_q <= ITER;
    end else if (cnt_q != '0) begin
      rem_q <= fits ? diff[W-1:0] : shifted[W-1:0];
      quo_q <= {quo_q[W-2:0], fits};
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ITER); // R4
  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (rem_q < dvs_q)); // R2
endmodule

// File: rtl/idiv_trap.sv
module idiv_trap (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic dvs_zero,
  input  logic exc_enable,
  input  logic zexc_suppress,
  output logic dz_status,
  output logic zero_pend,
  output logic exc_pend
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dz_status <= 1'b0;
      zero_pend <= 1'b0;
      exc_pend  <= 1'b0;
    end else if (accept) begin
      dz_status <= dvs_zero;
      zero_pend <= dvs_zero;
      exc_pend  <= dvs_zero & exc_enable & ~zexc_suppress;
    end
  end

  AST_EXC_NEEDS_DZ: assert property (@(posedge clk) disable iff (!rst_n)
    exc_pend |-> (dz_status && zero_pend)); // R7
  AST_DZ_SET_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dvs_zero) |=> dz_status); // R5
  AST_DZ_CLEAR_ON_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !dvs_zero) |=> !dz_status); // R6
endmodule

// File: rtl/idiv_unit.sv
module idiv_unit #(
  parameter int W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [W-1:0]                in_dividend,
  input  logic [W-1:0]                in_divisor,
  input  logic                        in_signed,
  input  logic                        exc_enable,
  input  logic                        zexc_suppress,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [W-1:0]                out_quotient,
  output logic                        dz_status,
  output logic                        exc_req,
  output logic [idiv_pkg::CAUSE_W-1:0] exc_cause
);
  import idiv_pkg::*;

  idiv_state_e  state_q;
  logic [W-1:0] dvd_mag, dvs_mag, quo_mag;
  logic         neg_q, neg_r, dvs_zero, last, accept, zero_pend, exc_pend;

  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid & in_ready;

  idiv_prep #(.W(W)) u_prep (
    .dividend (in_dividend),
    .divisor  (in_divisor),
    .is_signed(in_signed),
    .dvd_mag  (dvd_mag),
    .dvs_mag  (dvs_mag),
    .neg_q    (neg_q),
    .dvs_zero (dvs_zero)
  );

  idiv_core #(.W(W)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept & ~dvs_zero),
    .dvd_mag(dvd_mag),
    .dvs_mag(dvs_mag),
    .quo_mag(quo_mag),
    .last   (last)
  );

  idiv_trap u_trap (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .dvs_zero     (dvs_zero),
    .exc_enable   (exc_enable),
    .zexc_suppress(zexc_suppress),
    .dz_status    (dz_status),
    .zero_pend    (zero_pend),
    .exc_pend     (exc_pend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      neg_r   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= dvs_zero ? ST_HOLD : ST_RUN;
          neg_r   <= neg_q;
        end
        ST_RUN:  if (last) state_q <= ST_HOLD;
        ST_HOLD: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    out_valid    = (state_q == ST_HOLD);
    out_quotient = '0;
    if (out_valid && !zero_pend)
      out_quotient = neg_r ? (~quo_mag + 1'b1) : quo_mag;
    exc_req   = out_valid & exc_pend;
    exc_cause = exc_req ? CAUSE_DIVZERO : '0;
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_quotient) && $stable(exc_req))); // R9
  AST_READY_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid); // R9
  AST_ZERO_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_divisor == '0) |=> (out_valid && out_quotient == '0)); // R5
  AST_EXC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (exc_cause == CAUSE_DIVZERO && out_quotient == '0)); // R7
  AST_NOVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_quotient == '0 && !exc_req)); // R4
endmodule

// File: tb/sim_idiv_unit.sv
module sim_idiv_unit;
  localparam int W = 32;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_signed = 1'b0, exc_enable = 1'b0, zexc_suppress = 1'b0;
  logic out_ready = 1'b0;
  logic [W-1:0] in_dividend = '0, in_divisor = '0;
  logic in_ready, out_valid, dz_status, exc_req;
  logic [W-1:0] out_quotient;
  logic [4:0] exc_cause;

  int checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idiv_unit #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dividend(in_dividend), .in_divisor(in_divisor), .in_signed(in_signed),
    .exc_enable(exc_enable), .zexc_suppress(zexc_suppress),
    .out_valid(out_valid), .out_ready(out_ready), .out_quotient(out_quotient),
    .dz_status(dz_status), .exc_req(exc_req), .exc_cause(exc_cause)
  );

  // reference model: 0 idle, 1 running, 2 result held
  int m_st = 0, m_prev = 0, m_cnt = 0;
  logic [W-1:0] m_q = '0;
  logic m_dz = 1'b0, m_exc = 1'b0, m_zero = 1'b0, m_sgn = 1'b0, m_ovf = 1'b0;

  function automatic logic [W-1:0] ref_q(logic [W-1:0] a, logic [W-1:0] b, logic sgn);
    longint sa, sb, r;
    if (b == '0) return '0;
    if (sgn) begin sa = longint'($signed(a)); sb = longint'($signed(b)); end
    else begin sa = longint'({32'd0, a}); sb = longint'({32'd0, b}); end
    r = sa / sb;
    return r[W-1:0];
  endfunction

  always @(posedge clk) begin
    m_prev = m_st;
    if (!rst_n) begin
      m_st = 0; m_dz = 1'b0; m_exc = 1'b0; m_zero = 1'b0;
    end else begin
      case (m_st)
        0: if (in_valid) begin
          m_q    = ref_q(in_dividend, in_divisor, in_signed);
          m_zero = (in_divisor == '0);
          m_dz   = m_zero;
          m_exc  = m_zero && exc_enable && !zexc_suppress;
          m_sgn  = in_signed;
          m_ovf  = in_signed && in_dividend == 32'h8000_0000 && in_divisor == '1;
          if (m_zero) m_st = 2; else begin m_st = 1; m_cnt = W; end
        end
        1: begin m_cnt--; if (m_cnt == 0) m_st = 2; end
        default: if (out_ready) m_st = 0;
      endcase
    end
  end

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check("R9 in_ready", W'(in_ready), W'(m_st == 0));
      check((m_st == 2 && m_prev == 2) ? "R9 out_valid" : "R4 out_valid",
            W'(out_valid), W'(m_st == 2));
      check(m_st != 2 ? "R4 quotient idle" : m_zero ? "R5 quotient" : m_ovf ? "R8 quotient" :
            m_sgn ? "R3 quotient" : "R2 quotient", out_quotient, (m_st == 2) ? m_q : '0);
      check(m_dz ? "R5 dz_status" : "R6 dz_status", W'(dz_status), W'(m_dz));
      check("R7 exc_req", W'(exc_req), W'(m_st == 2 && m_exc));
      check("R7 exc_cause", W'(exc_cause), (m_st == 2 && m_exc) ? W'(5) : '0);
    end
  end

  task automatic run_div(logic [W-1:0] a, logic [W-1:0] b, logic sgn, logic en,
                         logic sup, int hold, bit wiggle);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_dividend = a; in_divisor = b; in_signed = sgn;
    exc_enable = en; zexc_suppress = sup;
    @(negedge clk);
    in_valid = 1'b0;
    if (wiggle) begin
      // R10: control bits flip after acceptance; R9: stray offer while busy
      exc_enable = ~en; zexc_suppress = ~sup;
      in_valid = 1'b1; in_dividend = 32'h1234_5678; in_divisor = 32'd3;
    end
    while (!out_valid) @(negedge clk);
    in_valid = 1'b0;
    if (wiggle) begin
      checks++;
      if (exc_req !== (b == '0 && en && !sup)) begin
        errors++;
        $display("FAIL R10 exc_req actual=%b expected=%b", exc_req, (b == '0 && en && !sup));
      end
    end
    repeat (hold) @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 in_ready", W'(in_ready), W'(1));
    check("R1 out_valid", W'(out_valid), '0);
    check("R1 dz_status", W'(dz_status), '0);
    check("R1 exc", W'({exc_req, exc_cause}), '0);
    rst_n = 1'b1;
    run_div(32'd100, 32'd7, 1'b0, 1'b1, 1'b0, 0, 1'b0);          // R2
    run_div(32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, 1'b0, 2, 1'b0);    // R2
    run_div(32'd7, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 0, 1'b0);    // R2
    run_div(-32'sd7, 32'd2, 1'b1, 1'b0, 1'b0, 0, 1'b0);          // R3
    run_div(32'd7, -32'sd2, 1'b1, 1'b0, 1'b0, 1, 1'b0);          // R3
    run_div(-32'sd7, -32'sd2, 1'b1, 1'b0, 1'b0, 0, 1'b0);        // R3
    run_div(32'd5, 32'd0, 1'b0, 1'b1, 1'b0, 3, 1'b0);            // R5 R7 trap
    run_div(32'd9, 32'd3, 1'b0, 1'b1, 1'b0, 0, 1'b0);            // R6 clears
    run_div(32'd5, 32'd0, 1'b1, 1'b0, 1'b0, 0, 1'b0);            // R7 disabled
    run_div(32'd5, 32'd0, 1'b1, 1'b1, 1'b1, 0, 1'b0);            // R7 suppressed
    run_div(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, 0, 1'b0); // R8
    run_div(32'd1000, 32'd10, 1'b0, 1'b1, 1'b0, 6, 1'b1);        // R9 R10
    run_div(32'd0, 32'd0, 1'b0, 1'b1, 1'b0, 4, 1'b1);            // R9 R10 zero
    run_div(32'd0, 32'd0, 1'b0, 1'b0, 1'b1, 0, 1'b1);            // R10
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] a, b;
      a = $urandom; b = $urandom >> ($urandom % 32);
      if (i % 9 == 0) b = '0;
      run_div(a, b, 1'(i), 1'($urandom), 1'($urandom), i % 3, 1'(i % 5 == 0)); // R2 R3
    end
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    errors++;
    $display("FAIL watchdog actual=%0d expected<100000", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule